// File: doc/BRIEF.md
# MSI Event Queue Controller

This block turns message-signalled interrupt writes from the PCIe side into entries in a set of circular event logs, one log per wired interrupt output. Each incoming write selects a vector from its offset inside the message window and picks a queue from that vector. The controller stores the write's data in the next free slot of that queue's log and moves the queue's tail pointer forward by one. The log sits in a small internal memory that stands in for host memory.

Software owns each queue's head pointer. It reads the tail and then reads entries from the log. It consumes an entry by writing head plus one back to the head register, and it repeats until head and tail are equal. The interrupt output of a queue is a level signal. It stays high while the queue holds unread entries and every enable that applies to the queue is set. When a queue is full, writes to it are dropped and a sticky flag is raised, so equal pointers always mean an empty queue. Writes to a queue that is turned off are also dropped and flagged.

The register bus uses word addresses. Read data comes back one cycle after the read strobe.

Top module: `msi_event_queue`

## Requirements
- R1: After reset every queue has head 0 and tail 0, its control word and status read 0, the global enable word reads 0, and all interrupt outputs are low.
- R2: An MSI write whose window offset is 4*v (v = msi_addr[MSG_AW-1:2]) goes to queue v mod NUM_Q. The write's low 16 data bits are stored in that queue's slot at the old tail, and the tail then advances by one, modulo 64. Reading slot s of queue q at word address 0x200 + 64*q + s returns the stored 16 bits in [15:0], with bits [31:16] reading zero.
- R3: A write that maps to a queue whose control bit 0 (queue enable) is clear leaves the tail and the log unchanged, and sets bit 1 of that queue's status word.
- R4: A write that maps to an enabled queue already holding 63 unread entries (tail minus head, modulo 64, equal to 63) is dropped. The tail is left unchanged and bit 0 of that queue's status word is set.
- R5: The interrupt output of queue q is high exactly when all of the following hold: its control bits 0, 1 and 11 are set, bit q of the global enable word (word address 0x20) is set, and head differs from tail. The control word (word address 4*q) keeps only bits 0, 1 and 11; all other bits read as zero.
- R6: A write to the head register (word address 4*q+1) with value h sets head to h[5:0] if (h - head) mod 64 does not exceed (tail - head) mod 64. Any other value sets head to the tail.
- R7: The tail register (word address 4*q+2) is read-only. A write to it leaves the tail unchanged.
- R8: The status word (word address 4*q+3) is write-one-to-clear: each bit written as 1 is cleared, and each bit written as 0 keeps its value.
- R9: reg_rvalid is high in exactly the cycle after reg_rd. Unmapped addresses, including the register slots of queue numbers at or above NUM_Q, read as zero.
- R10: Pointers wrap. An entry accepted while the tail is 63 is stored in slot 63, and the tail becomes 0. A queue with head 63 and tail 0 counts one pending entry and raises its interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msi_valid | input | 1 | An MSI posted write is present this cycle |
| msi_addr | input | MSG_AW | Byte offset of the write inside the message window |
| msi_data | input | 32 | Write data; the low 16 bits are logged |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | NUM_Q | Level interrupt per queue |

## Verification
The properties assume that the inputs carry known 0/1 values whenever reset is released. They also assume that the head pointer is moved only by register writes and the tail only by MSI writes. Because of this, a cycle with no strobe must leave both pointers untouched. The bench drives every strobe for exactly one cycle, away from the active edge. It never overlaps a read with a write, and it sends at most one MSI write per cycle. The full-queue check therefore sees a clean 63-entry occupancy before the dropped write arrives.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam int PTR_W        = 6;
  localparam int Q_DEPTH      = 1 << PTR_W;
  localparam int ENTRY_W      = 16;
  localparam int CTRL_QEN_BIT = 0;
  localparam int CTRL_EACH_BIT = 1;
  localparam int CTRL_IEN_BIT = 11;

  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic ien;
    logic each;
    logic qen;
  } qctrl_t;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HEAD = 2'd1,
    SEL_TAIL = 2'd2,
    SEL_STAT = 2'd3
  } qsel_e;

  function automatic ptr_t ptr_dist(input ptr_t from_p, input ptr_t to_p);
    return ptr_t'(to_p - from_p);
  endfunction
endpackage

// File: rtl/msiq_rst_sync.sv
module msiq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/msiq_route.sv
module msiq_route #(
  parameter int NUM_Q  = 6,
  parameter int MSG_AW = 12,
  parameter int QIDX_W = 3
) (
  input  logic                           msi_valid,
  input  logic [MSG_AW-1:0]              msi_addr,
  input  logic [31:0]                    msi_data,
  output logic [NUM_Q-1:0]               hit_q,
  output logic [QIDX_W-1:0]              qidx,
  output logic [msiq_pkg::ENTRY_W-1:0]   entry_val
);
  localparam int VEC_W = MSG_AW - 2;

  logic [VEC_W-1:0] vec;
  logic [VEC_W-1:0] qnum;
  logic             unused_bits;

  assign vec         = msi_addr[MSG_AW-1:2];
  assign qnum        = vec % VEC_W'(NUM_Q);
  assign qidx        = qnum[QIDX_W-1:0];
  assign entry_val   = msi_data[msiq_pkg::ENTRY_W-1:0];
  assign unused_bits = ^{msi_addr[1:0], msi_data[31:msiq_pkg::ENTRY_W]};

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) begin
      hit_q[i] = msi_valid && (qnum == VEC_W'(i));
    end
  end
endmodule

// File: rtl/msiq_ring.sv
module msiq_ring
  import msiq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  logic   ctrl_we,
  input  qctrl_t ctrl_wval,
  input  logic   head_we,
  input  ptr_t   head_wval,
  input  logic   stat_we,
  input  logic [1:0] stat_w1c,
  input  logic   gie_bit,
  output ptr_t   head,
  output ptr_t   tail,
  output qctrl_t ctrl,
  output logic [1:0] stat,
  output logic   accept,
  output logic   irq
);
  ptr_t       head_q, head_d, tail_q, tail_d, pend;
  qctrl_t     ctrl_q;
  logic [1:0] stat_q, stat_d;
  logic       full, drop_off, drop_full;
  logic       head_en, tail_en, ctrl_en, stat_en;

  assign pend      = ptr_dist(head_q, tail_q);
  assign full      = (pend == ptr_t'(Q_DEPTH - 1));
  assign accept    = push && ctrl_q.qen && !full;
  assign drop_off  = push && !ctrl_q.qen;
  assign drop_full = push && ctrl_q.qen && full;

  always_comb begin
    tail_d = tail_q + ptr_t'(1);

    if (ptr_dist(head_q, head_wval) > pend) head_d = tail_q;
    else                                    head_d = head_wval;

    stat_d = stat_q;
    if (stat_we) stat_d = stat_d & ~stat_w1c;
    stat_d = stat_d | {drop_off, drop_full};
  end

  assign tail_en = accept;
  assign head_en = head_we;
  assign ctrl_en = ctrl_we;
  assign stat_en = stat_we || drop_off || drop_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (tail_en) tail_q <= tail_d;
      if (head_en) head_q <= head_d;
      if (ctrl_en) ctrl_q <= ctrl_wval;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign ctrl = ctrl_q;
  assign stat = stat_q;
  assign irq  = ctrl_q.qen && ctrl_q.each && ctrl_q.ien && gie_bit && (head_q != tail_q);
endmodule

// File: rtl/msiq_store.sv
module msiq_store #(
  parameter int NUM_Q  = 6,
  parameter int QIDX_W = 3
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [QIDX_W+msiq_pkg::PTR_W-1:0] waddr,
  input  logic [msiq_pkg::ENTRY_W-1:0]  wdata,
  input  logic [QIDX_W+msiq_pkg::PTR_W-1:0] raddr,
  output logic [msiq_pkg::ENTRY_W-1:0]  rdata
);
  localparam int AW    = QIDX_W + msiq_pkg::PTR_W;
  localparam int DEPTH = NUM_Q * msiq_pkg::Q_DEPTH;

  logic [msiq_pkg::ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = ({1'b0, raddr} < (AW+1)'(DEPTH)) ? mem[raddr] : '0;
endmodule

// File: rtl/msiq_regs.sv
module msiq_regs
  import msiq_pkg::*;
#(
  parameter int NUM_Q         = 6,
  parameter int QIDX_W        = 3,
  parameter int REG_AW        = 10,
  parameter bit HAS_GLOBAL_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic                    reg_rd,
  input  logic [REG_AW-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  output logic                    reg_rvalid,
  input  ptr_t   [NUM_Q-1:0]      heads,
  input  ptr_t   [NUM_Q-1:0]      tails,
  input  qctrl_t [NUM_Q-1:0]      ctrls,
  input  logic   [NUM_Q-1:0][1:0] stats,
  input  logic [ENTRY_W-1:0]      mem_rdata,
  output logic [QIDX_W+PTR_W-1:0] mem_raddr,
  output logic [NUM_Q-1:0]        ctrl_we,
  output logic [NUM_Q-1:0]        head_we,
  output logic [NUM_Q-1:0]        stat_we,
  output qctrl_t                  ctrl_wval,
  output ptr_t                    head_wval,
  output logic [1:0]              stat_w1c,
  output logic [NUM_Q-1:0]        gie
);
  localparam int GIE_ADDR = 1 << (2 + QIDX_W);

  logic              is_mem, is_qreg, is_gie;
  logic [QIDX_W-1:0] mem_q, reg_q;
  qsel_e             sel;
  logic [31:0]       rdata_d, rdata_q;
  logic              rvalid_q;
  logic              unused_bits;

  assign is_mem    = reg_addr[REG_AW-1];
  assign mem_q     = reg_addr[PTR_W +: QIDX_W];
  assign mem_raddr = reg_addr[QIDX_W+PTR_W-1:0];
  assign is_qreg   = !is_mem && (reg_addr[REG_AW-2:2+QIDX_W] == '0);
  assign reg_q     = reg_addr[2 +: QIDX_W];
  assign sel       = qsel_e'(reg_addr[1:0]);
  assign is_gie    = (reg_addr == REG_AW'(GIE_ADDR));

  assign ctrl_wval   = '{ien: reg_wdata[CTRL_IEN_BIT], each: reg_wdata[CTRL_EACH_BIT],
                         qen: reg_wdata[CTRL_QEN_BIT]};
  assign head_wval   = reg_wdata[PTR_W-1:0];
  assign stat_w1c    = reg_wdata[1:0];
  assign unused_bits = ^{reg_wdata[31:12], reg_wdata[10:6]};

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) begin
      ctrl_we[i] = reg_wr && is_qreg && (reg_q == QIDX_W'(i)) && (sel == SEL_CTRL);
      head_we[i] = reg_wr && is_qreg && (reg_q == QIDX_W'(i)) && (sel == SEL_HEAD);
      stat_we[i] = reg_wr && is_qreg && (reg_q == QIDX_W'(i)) && (sel == SEL_STAT);
    end
  end

  generate
    if (HAS_GLOBAL_EN) begin : g_gie
      logic [NUM_Q-1:0] gie_q;
      logic             gie_en;
      assign gie_en = reg_wr && is_gie;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gie_q <= '0;
        else if (gie_en) gie_q <= reg_wdata[NUM_Q-1:0];
      end
      assign gie = gie_q;
    end else begin : g_no_gie
      assign gie = '1;
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    if (is_mem) begin
      for (int i = 0; i < NUM_Q; i++) begin
        if (mem_q == QIDX_W'(i)) rdata_d = {{(32-ENTRY_W){1'b0}}, mem_rdata};
      end
    end else if (is_qreg) begin
      for (int i = 0; i < NUM_Q; i++) begin
        if (reg_q == QIDX_W'(i)) begin
          unique case (sel)
            SEL_CTRL: begin
              rdata_d[CTRL_QEN_BIT]  = ctrls[i].qen;
              rdata_d[CTRL_EACH_BIT] = ctrls[i].each;
              rdata_d[CTRL_IEN_BIT]  = ctrls[i].ien;
            end
            SEL_HEAD: rdata_d[PTR_W-1:0] = heads[i];
            SEL_TAIL: rdata_d[PTR_W-1:0] = tails[i];
            SEL_STAT: rdata_d[1:0]       = stats[i];
            default:  rdata_d = '0;
          endcase
        end
      end
    end else if (is_gie) begin
      rdata_d[NUM_Q-1:0] = gie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= reg_rd;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/msi_event_queue.sv
module msi_event_queue
  import msiq_pkg::*;
#(
  parameter int NUM_Q         = 6,
  parameter int MSG_AW        = 12,
  parameter bit HAS_GLOBAL_EN = 1'b1,
  parameter int QIDX_W        = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  parameter int REG_AW        = PTR_W + QIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  input  logic [MSG_AW-1:0] msi_addr,
  input  logic [31:0]       msi_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic [NUM_Q-1:0]  irq
);
  logic                    rst_n_int;
  logic [NUM_Q-1:0]        hit_q, accepts, ctrl_we, head_we, stat_we, gie;
  logic [QIDX_W-1:0]       route_q;
  logic [ENTRY_W-1:0]      entry_val, mem_rdata;
  logic [QIDX_W+PTR_W-1:0] mem_raddr;
  ptr_t   [NUM_Q-1:0]      heads, tails;
  qctrl_t [NUM_Q-1:0]      ctrls;
  logic   [NUM_Q-1:0][1:0] stats;
  qctrl_t                  ctrl_wval;
  ptr_t                    head_wval, wr_ptr;
  logic [1:0]              stat_w1c;
  logic                    mem_we;

  msiq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  msiq_route #(.NUM_Q(NUM_Q), .MSG_AW(MSG_AW), .QIDX_W(QIDX_W)) u_route (
    .msi_valid(msi_valid), .msi_addr(msi_addr), .msi_data(msi_data),
    .hit_q(hit_q), .qidx(route_q), .entry_val(entry_val)
  );

  generate
    for (genvar g = 0; g < NUM_Q; g++) begin : g_ring
      msiq_ring u_ring (
        .clk(clk), .rst_n(rst_n_int), .push(hit_q[g]),
        .ctrl_we(ctrl_we[g]), .ctrl_wval(ctrl_wval),
        .head_we(head_we[g]), .head_wval(head_wval),
        .stat_we(stat_we[g]), .stat_w1c(stat_w1c), .gie_bit(gie[g]),
        .head(heads[g]), .tail(tails[g]), .ctrl(ctrls[g]), .stat(stats[g]),
        .accept(accepts[g]), .irq(irq[g])
      );
    end
  endgenerate

  always_comb begin
    wr_ptr = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (route_q == QIDX_W'(i)) wr_ptr = tails[i];
    end
  end

  assign mem_we = |accepts;

  msiq_store #(.NUM_Q(NUM_Q), .QIDX_W(QIDX_W)) u_store (
    .clk(clk), .we(mem_we), .waddr({route_q, wr_ptr}), .wdata(entry_val),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  msiq_regs #(.NUM_Q(NUM_Q), .QIDX_W(QIDX_W), .REG_AW(REG_AW),
              .HAS_GLOBAL_EN(HAS_GLOBAL_EN)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .heads(heads), .tails(tails), .ctrls(ctrls),
    .stats(stats), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .ctrl_we(ctrl_we), .head_we(head_we), .stat_we(stat_we),
    .ctrl_wval(ctrl_wval), .head_wval(head_wval), .stat_w1c(stat_w1c), .gie(gie)
  );
endmodule

// File: rtl/msiq_checker.sv
module msiq_checker #(
  parameter int NUM_Q = 6,
  parameter int PTR_W = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        msi_valid,
  input logic                        reg_wr,
  input logic                        reg_rd,
  input logic                        reg_rvalid,
  input logic [NUM_Q-1:0]            irq,
  input logic [NUM_Q-1:0][PTR_W-1:0] q_head,
  input logic [NUM_Q-1:0][PTR_W-1:0] q_tail
);
  localparam logic [PTR_W-1:0] ONE  = 1;
  localparam logic [PTR_W-1:0] FULL = '1;

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
      logic [PTR_W-1:0] fill;
      assign fill = q_tail[i] - q_head[i];

      assert_tail_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_valid |=> $stable(q_tail[i]));

      assert_tail_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid |=> (q_tail[i] == $past(q_tail[i])) || (q_tail[i] == $past(q_tail[i]) + ONE));

      assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == FULL) |=> $stable(q_tail[i]));

      assert_irq_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq[i] |-> (q_head[i] != q_tail[i]));

      assert_head_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(q_head[i]));
    end
  endgenerate

  assert_rvalid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_rvalid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
endmodule

bind msi_event_queue msiq_checker #(.NUM_Q(NUM_Q), .PTR_W(msiq_pkg::PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_rvalid(reg_rvalid), .irq(irq),
  .q_head(heads), .q_tail(tails)
);

// File: tb/sim_msi_event_queue.sv
`timescale 1ns/1ps
module sim_msi_event_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msi_valid;
  logic [11:0] msi_addr;
  logic [31:0] msi_data;
  logic        reg_wr, reg_rd;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [5:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  msi_event_queue u0 (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
    .msi_data(msi_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq)
  );

  typedef struct packed {
    logic [9:0]  vec;
    logic [31:0] data;
    logic [2:0]  q;
    logic [5:0]  slot;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{10'd0,    32'hBEEF_0000, 3'd0, 6'd0},
    '{10'd7,    32'hBEEF_0007, 3'd1, 6'd0},
    '{10'd13,   32'hBEEF_000D, 3'd1, 6'd1},
    '{10'd5,    32'hBEEF_0005, 3'd5, 6'd0},
    '{10'd6,    32'hBEEF_0006, 3'd0, 6'd1},
    '{10'd1023, 32'hBEEF_03FF, 3'd3, 6'd0},
    '{10'd12,   32'hBEEF_000C, 3'd0, 6'd2},
    '{10'd2,    32'hBEEF_0002, 3'd2, 6'd0}
  };

  function automatic logic [9:0] qa(input int q, input int sel);
    return 10'(q * 4 + sel);
  endfunction

  function automatic logic [9:0] ma(input int q, input int slot);
    return 10'(32'h200 + q * 64 + slot);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic reg_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic msi_send(input logic [9:0] vec, input logic [31:0] d);
    @(negedge clk);
    msi_valid = 1'b1; msi_addr = {vec, 2'b00}; msi_data = d;
    @(negedge clk);
    msi_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; msi_valid = 1'b0; msi_addr = '0; msi_data = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk_eq("R1 irq", {26'd0, irq}, 32'd0);
    reg_read(qa(0, 0), d); chk_eq("R1 ctrl q0", d, 32'd0);
    reg_read(qa(5, 1), d); chk_eq("R1 head q5", d, 32'd0);
    reg_read(qa(3, 2), d); chk_eq("R1 tail q3", d, 32'd0);
    reg_read(qa(2, 3), d); chk_eq("R1 status q2", d, 32'd0);
    reg_read(10'h020, d);  chk_eq("R1 gie", d, 32'd0);

    for (int q = 0; q < 6; q++) reg_write(qa(q, 0), 32'h0000_0803);
    reg_write(10'h020, 32'h3F);

    // R2: table walk of routed writes
    for (int k = 0; k < 8; k++) begin
      msi_send(TBL[k].vec, TBL[k].data);
      reg_read(qa(int'(TBL[k].q), 2), d);
      chk_eq("R2 tail", d, 32'(TBL[k].slot) + 32'd1);
      reg_read(ma(int'(TBL[k].q), int'(TBL[k].slot)), d);
      chk_eq("R2 entry", d, {16'h0, TBL[k].data[15:0]});
    end

    // R5: interrupt gating
    chk_eq("R5 irq pending", {26'd0, irq}, 32'h2F);
    reg_write(10'h020, 32'h3E);
    chk_eq("R5 gie gates q0", {26'd0, irq}, 32'h2E);
    reg_write(10'h020, 32'h3F);
    reg_write(qa(1, 0), 32'h0000_0801);
    chk_eq("R5 each bit gates q1", {26'd0, irq}, 32'h2D);
    reg_read(qa(1, 0), d); chk_eq("R5 ctrl readback", d, 32'h801);
    reg_write(qa(1, 0), 32'hFFFF_FFFF);
    reg_read(qa(1, 0), d); chk_eq("R5 ctrl unused bits", d, 32'h803);
    chk_eq("R5 irq restored", {26'd0, irq}, 32'h2F);

    // R6: head writes on q0 (head 0, tail 3)
    reg_write(qa(0, 1), 32'd1);
    reg_read(qa(0, 1), d); chk_eq("R6 head advance", d, 32'd1);
    reg_write(qa(0, 1), 32'd5);
    reg_read(qa(0, 1), d); chk_eq("R6 head clamp", d, 32'd3);
    chk_eq("R6 irq q0 cleared", {31'd0, irq[0]}, 32'd0);

    // R3 / R8: disabled queue drop and status clear
    reg_write(qa(4, 0), 32'd0);
    msi_send(10'd4, 32'h0000_1234);
    reg_read(qa(4, 2), d); chk_eq("R3 tail unchanged", d, 32'd0);
    reg_read(qa(4, 3), d); chk_eq("R3 status flag", d, 32'd2);
    chk_eq("R3 no irq q4", {31'd0, irq[4]}, 32'd0);
    reg_write(qa(4, 3), 32'd0);
    reg_read(qa(4, 3), d); chk_eq("R8 zero write keeps", d, 32'd2);
    reg_write(qa(4, 3), 32'd2);
    reg_read(qa(4, 3), d); chk_eq("R8 w1c clears", d, 32'd0);

    // R7: tail is read-only
    reg_write(qa(3, 2), 32'd9);
    reg_read(qa(3, 2), d); chk_eq("R7 tail read-only", d, 32'd1);

    // R4: fill q2 to 63 then overflow
    for (int k = 0; k < 62; k++) msi_send(10'd2, 32'h0000_0100 + 32'(k));
    reg_read(qa(2, 2), d); chk_eq("R4 tail at 63", d, 32'd63);
    msi_send(10'd8, 32'h0000_1111);
    reg_read(qa(2, 2), d); chk_eq("R4 full drop tail", d, 32'd63);
    reg_read(qa(2, 3), d); chk_eq("R4 overflow flag", d, 32'd1);

    // R10: wrap
    reg_write(qa(2, 1), 32'd63);
    chk_eq("R10 empty at 63", {31'd0, irq[2]}, 32'd0);
    msi_send(10'd2, 32'hBEEF_5A5A);
    reg_read(qa(2, 2), d); chk_eq("R10 tail wraps", d, 32'd0);
    reg_read(ma(2, 63), d); chk_eq("R10 slot 63", d, 32'h0000_5A5A);
    chk_eq("R10 irq after wrap", {31'd0, irq[2]}, 32'd1);

    // R9: read timing and unmapped space
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 10'h040;
    @(negedge clk);
    reg_rd = 1'b0;
    chk_eq("R9 rvalid high", {31'd0, reg_rvalid}, 32'd1);
    chk_eq("R9 unmapped zero", reg_rdata, 32'd0);
    @(negedge clk);
    chk_eq("R9 rvalid low", {31'd0, reg_rvalid}, 32'd0);
    reg_read(qa(6, 0), d); chk_eq("R9 queue 6 zero", d, 32'd0);

    finish_run();
  end
endmodule